// File: doc/BRIEF.md
# Prescaled Update Timer

This block is a 32-bit up-counting timer that sits on a plain memory-mapped register bus. The bus has separate read and write strobes, a word address and 32-bit data. A programmable prescaler sets how many input clock cycles pass per counter step. While the run bit is set, the counter climbs toward a reload limit. When it has reached that limit, the next counter step returns it to zero and raises an update event. If the update interrupt is enabled, the event sets a sticky status flag and drives a one-cycle interrupt pulse.

Software programs the run bit, the interrupt enable, the prescaler and the reload limit, and it may load the counter directly. Loading the counter or the reload limit restarts the prescale period at once. Writing a 1 to bit 0 of the event register puts the whole timer back into its reset state. Twelve further words are kept only as storage for channel, mode and transfer settings. They read back what was written and have no effect on counting.

The word address is the byte offset divided by four. The map is: run control at word 0, update-interrupt enable at word 3, status at word 4, event register at word 5, counter at word 9, prescaler at word 10 and reload limit at word 11. The storage-only words are 1, 2, 6, 7, 8, 13, 14, 15, 16, 18, 19 and 20.

Top module: `upd_timer`

## Requirements
- R1: After reset, every mapped word (0 to 11, 13 to 16, 18 to 20) reads 0 and the interrupt output is low.
- R2: Storage-only words (1, 2, 6, 7, 8, 13, 14, 15, 16, 18, 19, 20) and the full 32 bits of words 0, 3 and 5 read back the last value written. Unmapped words (12, 17, 21 to 31) read 0, and writes to them change nothing.
- R3: Bit 0 of word 0 is the run bit. While it is 0, the counter and the prescale count hold their values.
- R4: While running, the counter advances once every (prescaler + 1) input clock cycles. The prescale count restarts after each step.
- R5: Take a step at which the counter is at or above a nonzero reload limit. That step returns the counter to 0 and produces an update event, so the full period is (prescaler + 1) × (reload + 1) cycles.
- R6: When bit 0 of word 3 is set, an update event sets status bit 0 and drives the interrupt high for exactly one cycle. When that bit is clear, the counter still wraps, but the flag and the interrupt stay low.
- R7: A write to word 4 ANDs bit 0 of the written data into the flag. Writing 0 clears it, writing 1 leaves it unchanged, and no write can set it.
- R8: With a reload limit of 0, each counter step forces the counter to 0 and no update event ever occurs.
- R9: A write to word 9 loads the counter in that cycle, takes priority over a counter step and restarts the prescale count. If the loaded value is at or above the reload limit, the next step wraps and produces an event.
- R10: A write to word 5 with bit 0 set returns every register, the flag and the prescale count to their reset values. A write with bit 0 clear is only stored.
- R11: A write to word 11 restarts the prescale count, so the next counter step comes (prescaler + 1) cycles after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rstN | input | 1 | Active-low synchronous reset |
| busRd | input | 1 | Read strobe; read data is valid in the same cycle |
| busWr | input | 1 | Write strobe; takes effect at the rising edge |
| busAddr | input | 5 | Word address (byte offset / 4) |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, 0 when busRd is low |
| irqPulse | output | 1 | One-cycle update interrupt |

## Verification
The bench sweeps every combination of prescaler 0 to 3 and reload limit 1 to 4. For each combination it measures the cycles to the first event and between two events, against (prescaler + 1) × (reload + 1), which separates a wrong prescale compare from an off-by-one wrap. Further runs use the interrupt disabled, a zero reload limit, a counter loaded above the limit, and counter or reload writes in mid-period. Counter values read at chosen cycles show exactly when the prescale count restarts. The storage words are tested with address-tagged patterns, which expose decode aliasing. The event-register writes with bit 0 clear and set separate plain storage from a full reinitialization.

// File: rtl/upd_timer_pkg.sv
package upd_timer_pkg;

  // Word indices whose decode drives behaviour
  localparam int IDX_RUN   = 0;
  localparam int IDX_IRQEN = 3;
  localparam int IDX_STAT  = 4;
  localparam int IDX_EVT   = 5;
  localparam int IDX_CNT   = 9;
  localparam int IDX_PSC   = 10;
  localparam int IDX_ARR   = 11;

  localparam int NUM_SLOTS = 15;
  localparam int SLOT_W    = 4;
  localparam int SLOT_RUN   = 0;
  localparam int SLOT_IRQEN = 3;

  typedef struct packed {
    logic run;
    logic reinit;
    logic loadCnt;
    logic loadPsc;
    logic loadArr;
  } dpStrobe_t;

  // Maps a word index onto a plain storage slot: {hit, slot}
  function automatic logic [SLOT_W:0] slotOf(input logic [4:0] idx);
    case (idx)
      5'd0:  slotOf = {1'b1, 4'd0};
      5'd1:  slotOf = {1'b1, 4'd1};
      5'd2:  slotOf = {1'b1, 4'd2};
      5'd3:  slotOf = {1'b1, 4'd3};
      5'd5:  slotOf = {1'b1, 4'd4};
      5'd6:  slotOf = {1'b1, 4'd5};
      5'd7:  slotOf = {1'b1, 4'd6};
      5'd8:  slotOf = {1'b1, 4'd7};
      5'd13: slotOf = {1'b1, 4'd8};
      5'd14: slotOf = {1'b1, 4'd9};
      5'd15: slotOf = {1'b1, 4'd10};
      5'd16: slotOf = {1'b1, 4'd11};
      5'd18: slotOf = {1'b1, 4'd12};
      5'd19: slotOf = {1'b1, 4'd13};
      5'd20: slotOf = {1'b1, 4'd14};
      default: slotOf = '0;
    endcase
  endfunction

endpackage

// File: rtl/upd_timer_count.sv
module upd_timer_count
  import upd_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cntQ,
  output logic [DATA_W-1:0] pscQ,
  output logic [DATA_W-1:0] arrQ,
  output logic              updEvt
);

  logic [DATA_W-1:0] pscCnt;
  logic              tick;
  logic              atLimit;
  logic              arrZero;

  assign tick    = strb.run && (pscCnt >= pscQ);
  assign arrZero = (arrQ == '0);
  assign atLimit = !arrZero && (cntQ >= arrQ);
  // A counter load in the same cycle wins over the step
  assign updEvt  = tick && atLimit && !strb.loadCnt;

  always_ff @(posedge clk) begin
    if (!rstN || strb.reinit) begin
      pscQ <= '0;
      arrQ <= '0;
    end else begin
      if (strb.loadPsc) pscQ <= wdata;
      if (strb.loadArr) arrQ <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.reinit) begin
      pscCnt <= '0;
    end else if (strb.loadCnt || strb.loadArr) begin
      pscCnt <= '0;
    end else if (strb.run) begin
      pscCnt <= tick ? '0 : pscCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.reinit) begin
      cntQ <= '0;
    end else if (strb.loadCnt) begin
      cntQ <= wdata;
    end else if (tick) begin
      cntQ <= (arrZero || atLimit) ? '0 : cntQ + 1'b1;
    end
  end

endmodule

// File: rtl/upd_timer_regs.sv
module upd_timer_regs
  import upd_timer_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              updEvt,
  input  logic [DATA_W-1:0] cntVal,
  input  logic [DATA_W-1:0] pscVal,
  input  logic [DATA_W-1:0] arrVal,
  output dpStrobe_t         strb,
  output logic              flagQ,
  output logic              uieQ,
  output logic              irqPulse
);

  logic [DATA_W-1:0]    slotQ [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] slotWe;
  logic [SLOT_W:0]      slotMap;
  logic                 slotHit;
  logic [SLOT_W-1:0]    slotIdx;
  logic                 reinit;
  logic                 wrStat;

  assign slotMap = slotOf(5'(busAddr));
  assign slotHit = slotMap[SLOT_W];
  assign slotIdx = slotMap[SLOT_W-1:0];

  assign reinit = busWr && (busAddr == ADDR_W'(IDX_EVT)) && busWdata[0];
  assign wrStat = busWr && (busAddr == ADDR_W'(IDX_STAT));

  genvar s;
  generate
    for (s = 0; s < NUM_SLOTS; s++) begin : g_slotWe
      assign slotWe[s] = busWr && slotHit && (slotIdx == SLOT_W'(s));
    end
  endgenerate

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (!rstN || reinit)  slotQ[i] <= '0;
      else if (slotWe[i])   slotQ[i] <= busWdata;
    end
  end

  assign uieQ = slotQ[SLOT_IRQEN][0];

  always_ff @(posedge clk) begin
    if (!rstN || reinit) begin
      flagQ    <= 1'b0;
      irqPulse <= 1'b0;
    end else begin
      flagQ    <= (wrStat ? (flagQ & busWdata[0]) : flagQ) | (updEvt & uieQ);
      irqPulse <= updEvt & uieQ;
    end
  end

  always_comb begin
    strb.run     = slotQ[SLOT_RUN][0];
    strb.reinit  = reinit;
    strb.loadCnt = busWr && (busAddr == ADDR_W'(IDX_CNT));
    strb.loadPsc = busWr && (busAddr == ADDR_W'(IDX_PSC));
    strb.loadArr = busWr && (busAddr == ADDR_W'(IDX_ARR));
  end

  always_comb begin
    busRdata = '0;
    if (busRd) begin
      if (busAddr == ADDR_W'(IDX_STAT)) busRdata = {{(DATA_W-1){1'b0}}, flagQ};
      else if (busAddr == ADDR_W'(IDX_CNT)) busRdata = cntVal;
      else if (busAddr == ADDR_W'(IDX_PSC)) busRdata = pscVal;
      else if (busAddr == ADDR_W'(IDX_ARR)) busRdata = arrVal;
      else begin
        for (int i = 0; i < NUM_SLOTS; i++) begin
          if (slotHit && (slotIdx == SLOT_W'(i))) busRdata = slotQ[i];
        end
      end
    end
  end

endmodule

// File: rtl/upd_timer.sv
module upd_timer
  import upd_timer_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqPulse
);

  dpStrobe_t         strb;
  logic              updEvt;
  logic [DATA_W-1:0] cntQ;
  logic [DATA_W-1:0] pscQ;
  logic [DATA_W-1:0] arrQ;
  logic              flagQ;
  logic              uieQ;
  logic              runQ;

  assign runQ = strb.run;

  upd_timer_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_regs (
    .clk(clk), .rstN(rstN), .busRd(busRd), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .updEvt(updEvt), .cntVal(cntQ), .pscVal(pscQ), .arrVal(arrQ),
    .strb(strb), .flagQ(flagQ), .uieQ(uieQ), .irqPulse(irqPulse)
  );

  upd_timer_count #(.DATA_W(DATA_W)) i_count (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(busWdata),
    .cntQ(cntQ), .pscQ(pscQ), .arrQ(arrQ), .updEvt(updEvt)
  );

endmodule

// File: rtl/upd_timer_chk.sv
module upd_timer_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWr,
  input logic              irqPulse,
  input logic              flagQ,
  input logic              runQ,
  input logic              uieQ,
  input logic [DATA_W-1:0] cntQ,
  input logic [DATA_W-1:0] arrQ
);

  assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse);

  assert_irq_sets_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> flagQ);

  assert_irq_needs_enable_R6: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> $past(runQ && uieQ));

  assert_no_event_zero_limit_R8: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> ($past(arrQ) != '0));

  assert_hold_when_stopped_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(runQ) && !$past(busWr)) |-> $stable(cntQ));

  assert_flag_only_by_event_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagQ) |-> irqPulse);

endmodule

bind upd_timer upd_timer_chk #(.DATA_W(DATA_W)) i_chk (
  .clk(clk), .rstN(rstN), .busWr(busWr), .irqPulse(irqPulse),
  .flagQ(flagQ), .runQ(runQ), .uieQ(uieQ), .cntQ(cntQ), .arrQ(arrQ)
);

// File: tb/test_upd_timer.sv
module test_upd_timer;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busRd = 1'b0;
  logic        busWr = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqPulse;

  int checks = 0;
  int fails = 0;
  logic irqSeen;

  always #(CLK_PERIOD/2) clk = ~clk;

  upd_timer i_upd_timer (
    .clk(clk), .rstN(rstN), .busRd(busRd), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irqPulse(irqPulse)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=0x%08h exp=0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = 5'(idx); busWdata = d;
    @(posedge clk); #1;
    busWr = 1'b0; busWdata = '0;
  endtask

  task automatic rd(input int idx, output logic [31:0] v);
    busRd = 1'b1; busAddr = 5'(idx);
    #1; v = busRdata;
    busRd = 1'b0;
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      if (irqPulse) irqSeen = 1'b1;
    end
  endtask

  function automatic bit mapped(input int idx);
    return !(idx == 12 || idx == 17 || idx > 20);
  endfunction

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [31:0] v;
    logic [31:0] v0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset state
    for (int a = 0; a < 32; a++) begin
      rd(a, v);
      chk($sformatf("R1 reset word %0d", a), v, 32'h0);
    end
    chk("R1 irq low after reset", {31'b0, irqPulse}, 32'h0);

    // R2: storage words with address-tagged data (bit 0 clear)
    for (int a = 0; a < 32; a++) begin
      if (a != 4 && a != 9 && a != 10 && a != 11) wr(a, 32'hA500_0000 | (a << 8));
    end
    for (int a = 0; a < 32; a++) begin
      if (a != 4 && a != 9 && a != 10 && a != 11) begin
        rd(a, v);
        chk($sformatf("R2 word %0d", a), v, mapped(a) ? (32'hA500_0000 | (a << 8)) : 32'h0);
      end
    end

    // R10: bit0 clear is stored, bit0 set reinitializes
    wr(5, 32'h0000_0006);
    rd(5, v); chk("R10 event store", v, 32'h6);
    wr(10, 32'd7); wr(11, 32'd9); wr(9, 32'd3);
    wr(5, 32'h1);
    for (int a = 0; a < 21; a++) begin
      if (mapped(a)) begin
        rd(a, v);
        chk($sformatf("R10 reinit word %0d", a), v, 32'h0);
      end
    end

    // R4 R5 R6: sweep prescaler and reload limit
    for (int p = 0; p < 4; p++) begin
      for (int r = 1; r < 5; r++) begin
        int n;
        wr(10, 32'(p)); wr(11, 32'(r)); wr(9, 32'h0); wr(3, 32'h1);
        wr(0, 32'h1);
        n = 0;
        for (int k = 0; k < 200; k++) begin
          @(posedge clk); #1; n++;
          if (irqPulse) break;
        end
        chk($sformatf("R5 first period psc=%0d arr=%0d", p, r), 32'(n), 32'((p+1)*(r+1)));
        @(posedge clk); #1;
        chk("R6 pulse one cycle", {31'b0, irqPulse}, 32'h0);
        n = 1;
        for (int k = 0; k < 200; k++) begin
          if (irqPulse) break;
          @(posedge clk); #1; n++;
        end
        chk($sformatf("R4 period psc=%0d arr=%0d", p, r), 32'(n), 32'((p+1)*(r+1)));
        wr(0, 32'h0);
        rd(4, v); chk("R6 flag set", v, 32'h1);
        if (p == 3 && r == 4) begin
          // R7: AND semantics
          wr(4, 32'hFFFF_FFFF); rd(4, v); chk("R7 write one keeps flag", v, 32'h1);
          wr(4, 32'hFFFF_FFFE); rd(4, v); chk("R7 write zero clears", v, 32'h0);
          wr(4, 32'h1); rd(4, v); chk("R7 write cannot set", v, 32'h0);
        end else begin
          wr(4, 32'h0);
        end
      end
    end

    // R3: hold while stopped
    rd(9, v0); edges(10); rd(9, v);
    chk("R3 counter holds", v, v0);

    // R6: interrupt disabled, silent wrap at limit 4
    wr(3, 32'h0); wr(10, 32'h0); wr(11, 32'd4); wr(9, 32'h0);
    irqSeen = 1'b0;
    wr(0, 32'h1);
    edges(7);
    rd(9, v); chk("R5 wrap value after 7 steps", v, 32'd2);
    rd(4, v); chk("R6 no flag when disabled", v, 32'h0);
    chk("R6 no irq when disabled", {31'b0, irqSeen}, 32'h0);
    wr(0, 32'h0);

    // R8: zero reload limit
    wr(3, 32'h1); wr(11, 32'h0); wr(9, 32'd5);
    irqSeen = 1'b0;
    wr(0, 32'h1);
    edges(10);
    rd(9, v); chk("R8 counter forced to 0", v, 32'h0);
    chk("R8 no irq", {31'b0, irqSeen}, 32'h0);
    wr(0, 32'h0);

    // R9: loaded above limit wraps on next step
    wr(11, 32'd3); wr(9, 32'd10);
    rd(9, v); chk("R9 load immediate", v, 32'd10);
    wr(0, 32'h1);
    chk("R9 no irq before step", {31'b0, irqPulse}, 32'h0);
    @(posedge clk); #1;
    chk("R9 event on first step", {31'b0, irqPulse}, 32'h1);
    rd(9, v); chk("R9 counter wrapped", v, 32'h0);
    wr(0, 32'h0); wr(4, 32'h0);

    // R9: mid-run load restarts prescale (psc 2)
    wr(3, 32'h0); wr(10, 32'd2); wr(11, 32'd1000); wr(9, 32'h0);
    wr(0, 32'h1);
    edges(8);
    wr(9, 32'd50);
    edges(2); rd(9, v); chk("R9 held during restarted prescale", v, 32'd50);
    edges(1); rd(9, v); chk("R9 step after psc+1", v, 32'd51);

    // R11: reload write restarts prescale
    edges(1);
    wr(11, 32'd2000);
    rd(9, v0);
    edges(2); rd(9, v); chk("R11 held after reload write", v, v0);
    edges(1); rd(9, v); chk("R11 step after psc+1", v, v0 + 32'd1);

    // R10: reinit while running stops everything
    wr(5, 32'h1);
    irqSeen = 1'b0;
    edges(6);
    rd(9, v); chk("R10 counter cleared and stopped", v, 32'h0);
    rd(0, v); chk("R10 run bit cleared", v, 32'h0);
    rd(11, v); chk("R10 limit cleared", v, 32'h0);
    chk("R10 no irq", {31'b0, irqSeen}, 32'h0);

    finishRun();
  end

endmodule